// File: doc/BRIEF.md
# Port Pair Power and Lane Assignment Controller

This block sets the power state and the lane ownership for two serial ports that share one MAC. One port is even-numbered and the other is odd-numbered. When reset is released, the block takes one sample of each port's power-down strap. That sample sets the initial power state. Software can then change the power state at any time through a small register port.

The even port can run at two widths:

- **Wide (4x):** the even port owns all four physical lanes. The odd port keeps register access but loses PHY access.
- **Narrow (1x):** the even port keeps only lane A. The odd port may then use lane B.

A lane whose owning port is powered down is reported as unused. When the pair holds port 0, the even port's strap is ignored, so that port is powered down only by a register write.

All outputs come straight from flops. Their next value is computed from the next state of the configuration, so a register write shows up on the outputs at the clock edge that accepts it.

Top module: `port_pair_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `pwr_en`, `lane_own` and `odd_phy_en` is 0.
- R2: The straps are sampled on the first rising clock edge with `rst` low. At that edge `pwr_en[1]` becomes the inverse of `strap_pd[1]` (strap value 1 means power down).
- R3: Strap values that change after the sampling edge have no effect. Register address 2 reads the sampled raw straps in bits [1:0].
- R4: With `IS_PORT0_PAIR` set, `strap_pd[0]` is ignored and the even port comes up powered (`pwr_en[0]` = 1).
- R5: Register address 0 holds the power-down bits: bit 0 for the even port, bit 1 for the odd port, 1 = down. A write changes `pwr_en` and the readback at the edge that accepts it.
- R6: Register address 1 bit 0 selects the even-port width: 1 = 4x, 0 = 1x. After reset it is 4x.
- R7: `lane_own` holds lane k in bits [2k+1:2k], with lane A at k = 0. The codes are 00 unused, 01 even, 10 odd. In 4x mode every lane shows 01 and `odd_phy_en` is 0.
- R8: In 1x mode lane A shows 01, lane B shows 10, and lanes C and D show 00. `odd_phy_en` equals `pwr_en[1]`.
- R9: A lane whose owner port is powered down shows 00.
- R10: Writes to address 2 are ignored, and unmapped addresses read 0.
- R11: A register write in the sampling cycle wins over the strap value for the field it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_pd | input | 2 | Power-down straps, bit 0 even port, bit 1 odd port |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| pwr_en | output | 2 | Port power enables, bit 0 even, bit 1 odd |
| lane_own | output | 8 | Per-lane owner codes |
| odd_phy_en | output | 1 | Odd port has PHY access |

## Verification
The hardest case to reach is a register write in the single cycle when the straps are sampled. That cycle exists only once per reset, so the bench repeats reset and raises the write strobe on the same falling edge that releases reset. It then checks that the written field beats the strap while the strap readback still shows the raw pins. A second hard case is changing the straps after sampling: the bench moves them and checks that neither power nor readback follows. The vector walk then steps through width and power combinations so that each lane's code is seen with its owner both on and off.

// File: rtl/ppl_pkg.sv
package ppl_pkg;

    localparam int LANES     = 4;
    localparam int PORTS     = 2;
    localparam int OWN_W     = 2;
    localparam int LANE_BUS_W = LANES * OWN_W;

    localparam int ADDR_PWR   = 0;
    localparam int ADDR_MODE  = 1;
    localparam int ADDR_STRAP = 2;

    typedef enum logic [OWN_W-1:0] {
        OWN_NONE = 2'b00,
        OWN_EVEN = 2'b01,
        OWN_ODD  = 2'b10
    } lane_owner_e;

    typedef struct packed {
        logic             wide;
        logic [PORTS-1:0] pd;
    } port_cfg_t;

    // Owner of lane idx for a given configuration, gated by power
    function automatic lane_owner_e lane_owner(input int idx, input port_cfg_t c);
        lane_owner_e o;
        o = OWN_NONE;
        if (c.wide) begin
            if (!c.pd[0]) o = OWN_EVEN;
        end else if (idx == 0) begin
            if (!c.pd[0]) o = OWN_EVEN;
        end else if (idx == 1) begin
            if (!c.pd[1]) o = OWN_ODD;
        end
        return o;
    endfunction

endpackage

// File: rtl/ppl_strap_capture.sv
module ppl_strap_capture
    import ppl_pkg::*;
#(
    parameter bit IS_PORT0_PAIR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] strap_pd,
    output logic             cap_fire,
    output logic             cap_done,
    output logic [PORTS-1:0] cap_pd,
    output logic [PORTS-1:0] strap_q
);

    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b1;
            strap_q <= '0;
        end else if (pending) begin
            pending <= 1'b0;
            strap_q <= strap_pd;
        end
    end

    assign cap_fire = pending & ~rst;
    assign cap_done = ~pending;

    generate
        if (IS_PORT0_PAIR) begin : g_port0
            assign cap_pd = {strap_pd[1], 1'b0};
        end else begin : g_other
            assign cap_pd = strap_pd;
        end
    endgenerate

endmodule

// File: rtl/ppl_cfg_regs.sv
module ppl_cfg_regs
    import ppl_pkg::*;
#(
    parameter int AW           = 2,
    parameter int DW           = 8,
    parameter bit DEFAULT_WIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_fire,
    input  logic [PORTS-1:0] cap_pd,
    input  logic [PORTS-1:0] strap_q,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output port_cfg_t        cfg_d
);

    port_cfg_t cfg_q;
    logic      unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:PORTS];

    always_comb begin
        cfg_d = cfg_q;
        if (cap_fire) cfg_d.pd = cap_pd;
        if (reg_we) begin
            if (reg_addr == AW'(ADDR_PWR))  cfg_d.pd   = reg_wdata[PORTS-1:0];
            if (reg_addr == AW'(ADDR_MODE)) cfg_d.wide = reg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pd   <= '0;
            cfg_q.wide <= DEFAULT_WIDE;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_PWR))        reg_rdata = DW'(cfg_q.pd);
        else if (reg_addr == AW'(ADDR_MODE))  reg_rdata = DW'(cfg_q.wide);
        else if (reg_addr == AW'(ADDR_STRAP)) reg_rdata = DW'(strap_q);
    end

endmodule

// File: rtl/ppl_lane_router.sv
module ppl_lane_router
    import ppl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  live,
    input  port_cfg_t             cfg_d,
    output logic [PORTS-1:0]      pwr_en,
    output logic [LANE_BUS_W-1:0] lane_own,
    output logic                  odd_phy_en
);

    logic [LANE_BUS_W-1:0] lane_d;
    logic [PORTS-1:0]      pwr_d;
    logic                  phy_d;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign lane_d[gi*OWN_W +: OWN_W] = lane_owner(gi, cfg_d);
        end
    endgenerate

    assign pwr_d = ~cfg_d.pd;
    assign phy_d = ~cfg_d.wide & ~cfg_d.pd[1];

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            pwr_en     <= '0;
            lane_own   <= '0;
            odd_phy_en <= 1'b0;
        end else begin
            pwr_en     <= pwr_d;
            lane_own   <= lane_d;
            odd_phy_en <= phy_d;
        end
    end

endmodule

// File: rtl/port_pair_ctrl.sv
module port_pair_ctrl
    import ppl_pkg::*;
#(
    parameter int AW            = 2,
    parameter int DW            = 8,
    parameter bit DEFAULT_WIDE  = 1'b1,
    parameter bit IS_PORT0_PAIR = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PORTS-1:0]      strap_pd,
    input  logic                  reg_we,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic [PORTS-1:0]      pwr_en,
    output logic [LANE_BUS_W-1:0] lane_own,
    output logic                  odd_phy_en
);

    logic             cap_fire;
    logic             cap_done;
    logic [PORTS-1:0] cap_pd;
    logic [PORTS-1:0] strap_q;
    port_cfg_t        cfg_d;

    ppl_strap_capture #(.IS_PORT0_PAIR(IS_PORT0_PAIR)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .strap_pd (strap_pd),
        .cap_fire (cap_fire),
        .cap_done (cap_done),
        .cap_pd   (cap_pd),
        .strap_q  (strap_q)
    );

    ppl_cfg_regs #(.AW(AW), .DW(DW), .DEFAULT_WIDE(DEFAULT_WIDE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cap_fire  (cap_fire),
        .cap_pd    (cap_pd),
        .strap_q   (strap_q),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_d     (cfg_d)
    );

    ppl_lane_router u_route (
        .clk        (clk),
        .rst        (rst),
        .live       (cap_fire | cap_done),
        .cfg_d      (cfg_d),
        .pwr_en     (pwr_en),
        .lane_own   (lane_own),
        .odd_phy_en (odd_phy_en)
    );

endmodule

// File: rtl/port_pair_ctrl_chk.sv
module port_pair_ctrl_chk #(
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [1:0]    wdata_lo,
    input logic [1:0]    pwr_en,
    input logic [7:0]    lane_own,
    input logic          odd_phy_en,
    input logic          cap_done,
    input logic [1:0]    strap_q
);

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (pwr_en == 2'b00 && lane_own == 8'h00 && !odd_phy_en)); // R1

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
        cap_done |=> $stable(strap_q)); // R3

    AST_PWR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == AW'(0)) |=> (pwr_en == ~$past(wdata_lo))); // R5

    AST_WIDE_NO_PHY: assert property (@(posedge clk) disable iff (rst)
        (lane_own[3:2] == 2'b01) |-> !odd_phy_en); // R7

    AST_PHY_LANE_B: assert property (@(posedge clk) disable iff (rst)
        odd_phy_en |-> (lane_own[3:2] == 2'b10 && lane_own[7:4] == 4'b0000)); // R8

    AST_LANE_A_POWERED: assert property (@(posedge clk) disable iff (rst)
        (lane_own[1:0] == 2'b01) |-> pwr_en[0]); // R9

    AST_LANE_B_POWERED: assert property (@(posedge clk) disable iff (rst)
        (lane_own[3:2] == 2'b10) |-> pwr_en[1]); // R9

endmodule

bind port_pair_ctrl port_pair_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wdata_lo   (reg_wdata[1:0]),
    .pwr_en     (pwr_en),
    .lane_own   (lane_own),
    .odd_phy_en (odd_phy_en),
    .cap_done   (cap_done),
    .strap_q    (strap_q)
);

// File: tb/port_pair_ctrl_tb.sv
module port_pair_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] strap_pd;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] pwr_en;
    logic [7:0] lane_own;
    logic       odd_phy_en;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    port_pair_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .strap_pd   (strap_pd),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pwr_en     (pwr_en),
        .lane_own   (lane_own),
        .odd_phy_en (odd_phy_en)
    );

    // {addr[20:19], wdata[18:11], exp_pwr[10:9], exp_lane[8:1], exp_phy[0]}
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {2'd1, 8'h00, 2'b01, 8'b00000001, 1'b0},
        {2'd0, 8'h00, 2'b11, 8'b00001001, 1'b1},
        {2'd1, 8'h01, 2'b11, 8'b01010101, 1'b0},
        {2'd0, 8'h01, 2'b10, 8'b00000000, 1'b0},
        {2'd1, 8'h00, 2'b10, 8'b00001000, 1'b1},
        {2'd0, 8'h03, 2'b00, 8'b00000000, 1'b0},
        {2'd2, 8'hFF, 2'b00, 8'b00000000, 1'b0},
        {2'd3, 8'h00, 2'b00, 8'b00000000, 1'b0},
        {2'd0, 8'h00, 2'b11, 8'b00001001, 1'b1}
    };

    task automatic check(input logic [15:0] got, input logic [15:0] exp,
                         input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R8";
            1: return "R5";
            2: return "R7";
            3: return "R9";
            4: return "R9";
            5: return "R5";
            6: return "R10";
            7: return "R10";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; strap_pd = 2'b11; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(16'(pwr_en), 16'h0, "R1", "pwr_en in reset");
        check(16'(lane_own), 16'h0, "R1", "lane_own in reset");
        check(16'(odd_phy_en), 16'h0, "R1", "odd_phy_en in reset");

        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(16'(pwr_en[1]), 16'h0, "R2", "odd power after strap");
        check(16'(pwr_en[0]), 16'h1, "R4", "port0 strap ignored");
        check(16'(lane_own), 16'h55, "R6", "default 4x lanes");

        strap_pd = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(16'(pwr_en), 16'h1, "R3", "late strap change ignored");
        reg_addr = 2'd2;
        #1 check(16'(reg_rdata), 16'h03, "R3", "strap readback");
        reg_addr = 2'd1;
        #1 check(16'(reg_rdata), 16'h01, "R6", "mode readback default");

        for (int i = 0; i < NV; i++) begin
            reg_write(VEC[i][20:19], VEC[i][18:11]);
            check(16'(pwr_en), 16'(VEC[i][10:9]), vec_tag(i), $sformatf("vec %0d pwr_en", i));
            check(16'(lane_own), 16'(VEC[i][8:1]), vec_tag(i), $sformatf("vec %0d lane_own", i));
            check(16'(odd_phy_en), 16'(VEC[i][0]), vec_tag(i), $sformatf("vec %0d odd_phy_en", i));
        end

        reg_addr = 2'd0;
        #1 check(16'(reg_rdata), 16'h00, "R5", "power readback");
        reg_addr = 2'd2;
        #1 check(16'(reg_rdata), 16'h03, "R10", "strap reg unchanged by write");
        reg_addr = 2'd3;
        #1 check(16'(reg_rdata), 16'h00, "R10", "unmapped reads zero");

        // write in the sampling cycle
        @(negedge clk);
        rst = 1'b1; strap_pd = 2'b00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h02;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        check(16'(pwr_en), 16'h1, "R11", "write beats strap");
        check(16'(lane_own), 16'h55, "R11", "lanes after override");
        reg_addr = 2'd2;
        #1 check(16'(reg_rdata), 16'h00, "R11", "raw strap kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule